// File: doc/BRIEF.md
# Receive Message Index Queue with Full-Policy Select

This block keeps the bookkeeping for a circular queue of received-frame slots. Each completed frame reported on the write side claims the slot named by the write index, and software on the read side consumes frames in arrival order. Software sees the read index, the number of occupied slots, and a pulse input that releases the oldest slot. The frame storage, the acceptance filters and the bus protocol are kept elsewhere. This block only tracks the two indices, the occupancy count and the status flags.

A policy input sets what happens when a frame arrives while every slot is taken. In the discard policy the frame is dropped and a sticky lost flag is raised. In the replace policy the oldest entry is evicted so the new frame can be stored. A threshold input drives a level interrupt when occupancy reaches the threshold. Threshold values above 64 are clipped to 64, and a threshold of 0 turns the interrupt off.

Top module: `rxq_index_fifo`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it, `put_idx`, `get_idx`, `fill_lvl`, `msg_lost` and `fifo_full` are 0 and `fifo_empty` is 1.
- R2: A `frame_done` pulse while the queue is not full advances `put_idx` by one and raises `fill_lvl` by one. Both changes appear one clock after the pulse.
- R3: A `read_ack` pulse while `fill_lvl` is nonzero advances `get_idx` by one and lowers `fill_lvl` by one. A `read_ack` while `fill_lvl` is 0 leaves `get_idx` and `fill_lvl` unchanged.
- R4: With `ovw_mode`=0 (discard policy, the value to use after reset), a `frame_done` while full and without `read_ack` leaves `put_idx`, `get_idx` and `fill_lvl` unchanged and sets `msg_lost`.
- R5: With `ovw_mode`=1 (replace policy), a `frame_done` while full and without `read_ack` advances both `put_idx` and `get_idx` by one. `fill_lvl` stays at DEPTH and `msg_lost` is not set.
- R6: `frame_done` and `read_ack` in the same cycle with a nonzero `fill_lvl` advance both indices and leave `fill_lvl` unchanged, even when the queue is full.
- R7: `msg_lost` stays 1 until a `lost_clr` pulse clears it. A drop in the same cycle as `lost_clr` leaves it 1.
- R8: `wm_irq` is 1 exactly when `wm_level` is nonzero and `fill_lvl` is at least min(`wm_level`, 64). It follows `fill_lvl` and `wm_level` with no extra cycle.
- R9: With `wm_level`=0, `wm_irq` is 0 at every fill level.
- R10: Both indices step from DEPTH-1 back to 0.
- R11: `fifo_full` is 1 exactly when `fill_lvl` equals DEPTH, `fifo_empty` is 1 exactly when it is 0, and `fill_lvl` never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | A received frame has finished and wants a slot |
| ovw_mode | input | 1 | Full policy: 0 discard new frame, 1 replace oldest |
| read_ack | input | 1 | Software has consumed the entry at `get_idx` |
| lost_clr | input | 1 | Clears the lost-frame flag |
| wm_level | input | 8 | Occupancy threshold for `wm_irq`; 0 turns it off |
| put_idx | output | $clog2(DEPTH) | Slot the next frame is written to |
| get_idx | output | $clog2(DEPTH) | Oldest unread slot |
| fill_lvl | output | $clog2(DEPTH+1) | Number of occupied slots |
| fifo_full | output | 1 | All slots occupied |
| fifo_empty | output | 1 | No slot occupied |
| wm_irq | output | 1 | Occupancy has reached the threshold |
| msg_lost | output | 1 | Sticky: a frame was discarded |

## Verification
The indices, the occupancy count, the full and empty flags and the lost flag are registered. Each reflects a `frame_done`, `read_ack` or `lost_clr` pulse at the first rising edge that samples the pulse. `wm_irq` is combinational from the registered count and the `wm_level` input, so it settles in the same cycle as the count, and immediately after a change of `wm_level`. The bench drives every stimulus on a falling edge and holds it across exactly one rising edge. It samples all outputs at the following falling edge, one settled half-period after the edge that was due to update them.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Highest usable occupancy threshold; larger requests are clipped.
    localparam int unsigned WM_CAP = 64;

    typedef logic [7:0] wm_t;

    typedef enum logic {
        MODE_DISCARD = 1'b0,
        MODE_REPLACE = 1'b1
    } full_mode_e;

    // Per-cycle decision carried from the arbiter to the counters.
    typedef struct packed {
        logic adv_put;
        logic adv_get;
        logic drop;
    } step_t;

    function automatic step_t plan_step(
        input logic       wr,
        input logic       ack,
        input logic       is_full,
        input logic       is_empty,
        input full_mode_e mode
    );
        step_t s;
        s         = '0;
        s.adv_get = ack && !is_empty;
        if (wr) begin
            if (!is_full || s.adv_get) begin
                s.adv_put = 1'b1;
            end else if (mode == MODE_REPLACE) begin
                s.adv_put = 1'b1;
                s.adv_get = 1'b1;
            end else begin
                s.drop = 1'b1;
            end
        end
        return s;
    endfunction

    function automatic wm_t wm_clip(input wm_t raw);
        return (32'(raw) > WM_CAP) ? wm_t'(WM_CAP) : raw;
    endfunction

endpackage

// File: rtl/rxq_ptr.sv
module rxq_ptr #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [IW-1:0] idx
);

    logic [IW-1:0] nxt;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            // Natural wrap of the index width.
            assign nxt = idx + 1'b1;
        end else begin : g_any
            assign nxt = (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (adv) begin
            idx <= nxt;
        end
    end

    // R10: the index wraps from the last slot to slot zero
    p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (adv && idx == IW'(DEPTH - 1)) |=> (idx == '0));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(idx));

endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] fill,
    output logic          full,
    output logic          empty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign full  = (fill == CW'(DEPTH));
    assign empty = (fill == '0);

    // R11: occupancy never passes the slot count
    p_fill_cap_r11: assert property (@(posedge clk) disable iff (rst)
        32'(fill) <= DEPTH);

    // R11: the arbiter never requests growth of a full queue
    p_no_grow_full_r11: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec) |-> !full);

    // R3: the arbiter never requests shrink of an empty queue
    p_no_shrink_empty_r3: assert property (@(posedge clk) disable iff (rst)
        dec |-> !empty);

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int unsigned FW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          drop,
    input  logic          clr,
    input  logic [FW-1:0] fill,
    input  wm_t           wm_raw,
    output logic          lost,
    output logic          wm_hit
);

    wm_t         thr;
    int unsigned fill_u;

    always_ff @(posedge clk) begin
        if (rst) begin
            lost <= 1'b0;
        end else if (drop) begin
            lost <= 1'b1;
        end else if (clr) begin
            lost <= 1'b0;
        end
    end

    always_comb begin
        thr    = wm_clip(wm_raw);
        fill_u = 32'(fill);
        wm_hit = (thr != '0) && (fill_u >= 32'(thr));
    end

    // R4: a discarded frame always raises the lost flag
    p_drop_sets_r4: assert property (@(posedge clk) disable iff (rst)
        drop |=> lost);

    // R7: the lost flag holds until it is cleared
    p_lost_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (lost && !clr) |=> lost);

    // R9: a zero threshold never produces an interrupt
    always_ff @(posedge clk) begin
        if (!rst) begin
            p_wm_off_r9: assert (!(wm_hit && wm_raw == '0));
        end
    end

endmodule

// File: rtl/rxq_index_fifo.sv
module rxq_index_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_done,
    input  logic          ovw_mode,
    input  logic          read_ack,
    input  logic          lost_clr,
    input  logic [7:0]    wm_level,
    output logic [IW-1:0] put_idx,
    output logic [IW-1:0] get_idx,
    output logic [CW-1:0] fill_lvl,
    output logic          fifo_full,
    output logic          fifo_empty,
    output logic          wm_irq,
    output logic          msg_lost
);

    step_t      step;
    full_mode_e mode;

    assign mode = full_mode_e'(ovw_mode);

    always_comb begin
        step = plan_step(frame_done, read_ack, fifo_full, fifo_empty, mode);
    end

    rxq_ptr #(.DEPTH(DEPTH)) u_put (
        .clk (clk),
        .rst (rst),
        .adv (step.adv_put),
        .idx (put_idx)
    );

    rxq_ptr #(.DEPTH(DEPTH)) u_get (
        .clk (clk),
        .rst (rst),
        .adv (step.adv_get),
        .idx (get_idx)
    );

    rxq_level #(.DEPTH(DEPTH)) u_lvl (
        .clk   (clk),
        .rst   (rst),
        .inc   (step.adv_put),
        .dec   (step.adv_get),
        .fill  (fill_lvl),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    rxq_flags #(.FW(CW)) u_flg (
        .clk    (clk),
        .rst    (rst),
        .drop   (step.drop),
        .clr    (lost_clr),
        .fill   (fill_lvl),
        .wm_raw (wm_level),
        .lost   (msg_lost),
        .wm_hit (wm_irq)
    );

    // R4: discard policy leaves both indices alone when full
    p_discard_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && frame_done && !read_ack && !ovw_mode)
        |=> ($stable(put_idx) && $stable(get_idx) && msg_lost));

    // R5: replace policy evicts the oldest entry and stays full
    p_replace_evict_r5: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && frame_done && !read_ack && ovw_mode)
        |=> (fifo_full && get_idx != $past(get_idx) && put_idx != $past(put_idx)));

    // R3: an acknowledge on an empty queue does nothing
    p_empty_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && read_ack && !frame_done) |=> ($stable(get_idx) && fifo_empty));

    // R6: a write together with a read keeps the level
    p_both_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_done && read_ack && !fifo_empty) |=> $stable(fill_lvl));

endmodule

// File: tb/rxq_index_fifo_test.sv
`timescale 1ns/1ps
module rxq_index_fifo_test;

    localparam int DEPTH = 64;
    localparam int IW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          frame_done;
    logic          ovw_mode;
    logic          read_ack;
    logic          lost_clr;
    logic [7:0]    wm_level;
    logic [IW-1:0] put_idx;
    logic [IW-1:0] get_idx;
    logic [CW-1:0] fill_lvl;
    logic          fifo_full;
    logic          fifo_empty;
    logic          wm_irq;
    logic          msg_lost;

    int total = 0;
    int bad   = 0;

    // Expected state built from the requirements.
    int m_put, m_get, m_fill, m_lost;

    always #2 clk = ~clk;

    rxq_index_fifo #(.DEPTH(DEPTH)) uut (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .ovw_mode   (ovw_mode),
        .read_ack   (read_ack),
        .lost_clr   (lost_clr),
        .wm_level   (wm_level),
        .put_idx    (put_idx),
        .get_idx    (get_idx),
        .fill_lvl   (fill_lvl),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .wm_irq     (wm_irq),
        .msg_lost   (msg_lost)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, "put_idx", int'(put_idx), m_put);
        chk(req, "get_idx", int'(get_idx), m_get);
        chk(req, "fill_lvl", int'(fill_lvl), m_fill);
        chk(req, "msg_lost", int'(msg_lost), m_lost);
        chk("R11", "fifo_full", int'(fifo_full), int'(m_fill == DEPTH));
        chk("R11", "fifo_empty", int'(fifo_empty), int'(m_fill == 0));
    endtask

    function automatic int wm_expect(input int w, input int f);
        int t;
        t = (w > 64) ? 64 : w;
        return (t != 0 && f >= t) ? 1 : 0;
    endfunction

    // Drive one cycle of stimulus on a falling edge, update the model.
    task automatic cyc(input logic wr, input logic ack, input logic clr);
        bit a_get, a_put, drop;
        frame_done = wr;
        read_ack   = ack;
        lost_clr   = clr;
        @(posedge clk);
        a_get = ack && (m_fill > 0);
        a_put = 1'b0;
        drop  = 1'b0;
        if (wr) begin
            if (m_fill < DEPTH || a_get) a_put = 1'b1;
            else if (ovw_mode) begin a_put = 1'b1; a_get = 1'b1; end
            else drop = 1'b1;
        end
        if (a_put) m_put = (m_put + 1) % DEPTH;
        if (a_get) m_get = (m_get + 1) % DEPTH;
        m_fill = m_fill + int'(a_put) - int'(a_get);
        if (drop) m_lost = 1;
        else if (clr) m_lost = 0;
        @(negedge clk);
        frame_done = 1'b0;
        read_ack   = 1'b0;
        lost_clr   = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        frame_done = 1'b0; read_ack = 1'b0; lost_clr = 1'b0;
        ovw_mode = 1'b0; wm_level = 8'd0;
        m_put = 0; m_get = 0; m_fill = 0; m_lost = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_state("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_state("R1");
    endtask

    task automatic t_fill;
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 1'b0);
        chk("R2", "put after 10 writes", int'(put_idx), 10);
        chk("R2", "fill after 10 writes", int'(fill_lvl), 10);
        chk_state("R2");
    endtask

    task automatic t_ack;
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0);
        chk("R3", "get after 3 acks", int'(get_idx), 3);
        chk_state("R3");
    endtask

    task automatic t_wm;
        int levels[5] = '{7, 8, 0, 1, 200};
        foreach (levels[k]) begin
            wm_level = 8'(levels[k]);
            #1;
            chk(levels[k] == 0 ? "R9" : "R8", "wm_irq", int'(wm_irq), wm_expect(levels[k], m_fill));
        end
        wm_level = 8'd8;
        cyc(1'b1, 1'b0, 1'b0);
        chk("R8", "wm_irq at threshold", int'(wm_irq), 1);
        chk_state("R2");
    endtask

    task automatic t_block;
        ovw_mode = 1'b0;
        while (m_fill < DEPTH) cyc(1'b1, 1'b0, 1'b0);
        chk_state("R11");
        chk("R11", "full at depth", int'(fifo_full), 1);
        wm_level = 8'd200;
        #1;
        chk("R8", "wm saturates to 64", int'(wm_irq), 1);
        wm_level = 8'd0;
        #1;
        chk("R9", "wm off at full", int'(wm_irq), 0);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R4", "lost after drop", int'(msg_lost), 1);
        chk_state("R4");
        cyc(1'b0, 1'b0, 1'b0);
        chk("R7", "lost sticky", int'(msg_lost), 1);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R7", "lost cleared", int'(msg_lost), 0);
        cyc(1'b1, 1'b0, 1'b1);
        chk("R7", "drop beats clear", int'(msg_lost), 1);
        chk_state("R4");
        cyc(1'b0, 1'b0, 1'b1);
        chk_state("R7");
    endtask

    task automatic t_both_full;
        int p0;
        p0 = m_put;
        cyc(1'b1, 1'b1, 1'b0);
        chk("R6", "fill kept", int'(fill_lvl), DEPTH);
        chk("R6", "put advanced", int'(put_idx), (p0 + 1) % DEPTH);
        chk("R6", "no loss", int'(msg_lost), 0);
        chk_state("R6");
    endtask

    task automatic t_replace;
        int g0;
        ovw_mode = 1'b1;
        g0 = m_get;
        cyc(1'b1, 1'b0, 1'b0);
        chk("R5", "get evicted", int'(get_idx), (g0 + 1) % DEPTH);
        chk("R5", "still full", int'(fill_lvl), DEPTH);
        chk("R5", "no loss flag", int'(msg_lost), 0);
        chk_state("R5");
        // Keep replacing until the get index wraps through the last slot.
        while (m_get != 0) cyc(1'b1, 1'b0, 1'b0);
        chk("R10", "get wrapped", int'(get_idx), 0);
        chk_state("R10");
        ovw_mode = 1'b0;
    endtask

    task automatic t_drain;
        while (m_fill > 0) cyc(1'b0, 1'b1, 1'b0);
        chk_state("R3");
        cyc(1'b0, 1'b1, 1'b0);
        chk("R3", "ack on empty ignored", int'(fill_lvl), 0);
        chk_state("R3");
        cyc(1'b1, 1'b1, 1'b0);
        chk("R3", "empty ack with write", int'(fill_lvl), 1);
        chk_state("R2");
        cyc(1'b1, 1'b1, 1'b0);
        chk_state("R6");
    endtask

    task automatic t_wrap_put;
        // Walk the write index across the last slot with a read each time.
        for (int i = 0; i < DEPTH + 2; i++) cyc(1'b1, 1'b1, 1'b0);
        chk_state("R10");
    endtask

    initial begin : watchdog
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_fill();
        t_ack();
        t_wm();
        t_block();
        t_both_full();
        t_replace();
        t_drain();
        t_wrap_put();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule